// File: doc/BRIEF.md
# RTC Periodic Rate and Divider Control

This block turns a 32.768 kHz oscillator clock enable into the timing signals of a real-time clock. A binary divider chain of fifteen stages counts the oscillator ticks. A 4-bit rate code selects one stage through a single multiplexer. That one selected signal is the square-wave output, and its rising edge is also the periodic event that feeds the interrupt logic. The topmost stage gives a 1 Hz update strobe for the calendar counters.

A 3-bit oscillator code drives a three-state controller. The states are OSC_OFF, DIV_HOLD and DIV_RUN. Code 010 leads to DIV_RUN, where the oscillator runs and the divider counts. Codes 110 and 111 lead to DIV_HOLD, where the oscillator runs and the divider is held cleared. Every other code leads to OSC_OFF, where the oscillator is stopped and the divider is frozen. The controller registers the code each cycle, and every state can move straight to any other. The transitions are named START (OSC_OFF to DIV_RUN), PARK (OSC_OFF to DIV_HOLD), RELEASE (DIV_HOLD to DIV_RUN), HALT (any state to OSC_OFF) and CLEAR (DIV_RUN to DIV_HOLD). Any other move is a self-loop.

The periodic event pulse is produced whether or not interrupts are enabled. The enable input only gates the interrupt request output.

Top module: `rtc_periodic_gen`

## Requirements
- R1: After reset, osc_en, sqw, per_event, per_irq and upd_strobe are all 0.
- R2: One clock cycle after osc_ctl is sampled, osc_en is 1 if that code was 010, 110 or 111, and 0 for any other code.
- R3: While osc_ctl is 110 or 111, the divider is held cleared. sqw, per_event and upd_strobe then stay 0 at any rate code.
- R4: While osc_ctl is any code other than 010, 110 or 111, the divider keeps its count and does not advance. No per_event occurs. Once 010 returns, counting resumes at the same period.
- R5: The tap period is 2^(n-1) counted ticks for rate code n from 3 to 15. That is 4 ticks (122.07 µs) at code 3 and 16384 ticks (500 ms) at code 15. Code 1 gives 128 ticks and code 2 gives 256 ticks.
- R6: Rate code 0 holds sqw at 0 and produces no per_event.
- R7: sqw is high for exactly half of each tap period.
- R8: per_event is a one-cycle pulse in the first cycle that sqw is high in each period. It occurs whether pie is 0 or 1.
- R9: per_irq is 1 exactly when per_event is 1 and pie was 1 at the same sampling edge. With pie at 0, per_irq stays 0.
- R10: When the divider leaves DIV_HOLD, the first one-cycle upd_strobe is visible two clock cycles after the 16384th counted tick, that is, 500 ms later. After that, a strobe follows every 32768 ticks.
- R11: Only cycles with osc_tick at 1 advance the divider. With a tick every second cycle, rate code 3 gives a period of 8 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | 32.768 kHz oscillator clock enable |
| osc_ctl | input | 3 | Oscillator and divider control code |
| rate_sel | input | 4 | Periodic and square-wave rate code |
| pie | input | 1 | Periodic interrupt enable |
| osc_en | output | 1 | Oscillator run enable |
| sqw | output | 1 | Square-wave output (selected tap) |
| per_event | output | 1 | One-cycle periodic event pulse |
| per_irq | output | 1 | Periodic interrupt request pulse |
| upd_strobe | output | 1 | One-cycle 1 Hz update strobe |

## Verification
The update strobe and the square wave both come from one counter. At rate code 15, the count at which the 1 Hz stage rises is the same count at which the selected tap falls. The bench releases the divider from hold at rate code 15 and counts cycles from the release. It expects the first periodic event at cycle 8194. At cycle 16386 it expects the first strobe, with sqw just dropped to 0 and no periodic event in that same cycle. It expects the next strobe at cycle 49154.

// File: rtl/rtc_periodic_pkg.sv
package rtc_periodic_pkg;

    // oscillator / divider controller states
    typedef enum logic [1:0] {
        OSC_OFF  = 2'd0,
        DIV_HOLD = 2'd1,
        DIV_RUN  = 2'd2
    } osc_state_e;

    localparam int CTL_W       = 3;
    localparam int RATE_W      = 4;
    localparam int DIV_STAGES  = 15;

    // rate codes 1 and 2 reuse the taps of codes 8 and 9
    localparam int LOW_CODE_BASE = 6;
    // code n (n >= 3) selects stage n - RATE_OFFSET
    localparam int RATE_OFFSET   = 2;

    localparam logic [CTL_W-1:0] CTL_RUN = 3'b010;

    function automatic osc_state_e decode_ctl(input logic [CTL_W-1:0] code);
        osc_state_e s;
        if (code == CTL_RUN) begin
            s = DIV_RUN;
        end else if (code[2:1] == 2'b11) begin
            s = DIV_HOLD;
        end else begin
            s = OSC_OFF;
        end
        return s;
    endfunction

    function automatic int tap_index(input logic [RATE_W-1:0] code);
        int idx;
        if (code == '0) begin
            idx = 0;
        end else if (code < 3) begin
            idx = LOW_CODE_BASE + int'(code) - 1;
        end else begin
            idx = int'(code) - RATE_OFFSET;
        end
        return idx;
    endfunction

endpackage

// File: rtl/rtc_osc_ctrl.sv
module rtc_osc_ctrl
    import rtc_periodic_pkg::*;
#(
    parameter int CW = CTL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] osc_ctl,
    input  logic          osc_tick,
    output logic          osc_en,
    output logic          div_clr,
    output logic          div_adv
);

    osc_state_e state_q;
    osc_state_e state_d;
    osc_state_e target;

    assign target = decode_ctl(osc_ctl);

    // next-state selection with named transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OSC_OFF: begin
                if (target == DIV_RUN) begin
                    state_d = DIV_RUN;      // START
                end else if (target == DIV_HOLD) begin
                    state_d = DIV_HOLD;     // PARK
                end
            end
            DIV_HOLD: begin
                if (target == DIV_RUN) begin
                    state_d = DIV_RUN;      // RELEASE
                end else if (target == OSC_OFF) begin
                    state_d = OSC_OFF;      // HALT
                end
            end
            DIV_RUN: begin
                if (target == DIV_HOLD) begin
                    state_d = DIV_HOLD;     // CLEAR
                end else if (target == OSC_OFF) begin
                    state_d = OSC_OFF;      // HALT
                end
            end
            default: state_d = OSC_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OSC_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        osc_en  = 1'b0;
        div_clr = 1'b0;
        div_adv = 1'b0;
        unique case (state_q)
            OSC_OFF:  begin
                osc_en = 1'b0;
            end
            DIV_HOLD: begin
                osc_en  = 1'b1;
                div_clr = 1'b1;
            end
            DIV_RUN:  begin
                osc_en  = 1'b1;
                div_adv = osc_tick;
            end
            default:  begin
                osc_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain #(
    parameter int STAGES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [STAGES-1:0] taps
);

    logic [STAGES:0]   carry;
    logic [STAGES-1:0] cnt_q;

    assign carry[0] = adv;

    // one toggle stage per divider bit, rippled carry
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        assign carry[i+1] = carry[i] & cnt_q[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[i] <= 1'b0;
            end else if (clr) begin
                cnt_q[i] <= 1'b0;
            end else if (carry[i]) begin
                cnt_q[i] <= ~cnt_q[i];
            end
        end
    end

    assign taps = cnt_q;

endmodule

// File: rtl/rtc_rate_mux.sv
module rtc_rate_mux
    import rtc_periodic_pkg::*;
#(
    parameter int STAGES = DIV_STAGES,
    parameter int RW     = RATE_W
) (
    input  logic [STAGES-1:0] taps,
    input  logic [RW-1:0]     rate_sel,
    output logic              tap_out
);

    localparam int CODES = 1 << RW;

    logic [CODES-1:0] code_taps;

    // one candidate per rate code; code 0 is tied low
    for (genvar c = 0; c < CODES; c++) begin : g_code
        localparam int IDX = tap_index(RW'(c));
        if (c == 0 || IDX >= STAGES) begin : g_off
            assign code_taps[c] = 1'b0;
        end else begin : g_on
            assign code_taps[c] = taps[IDX];
        end
    end

    assign tap_out = code_taps[rate_sel];

endmodule

// File: rtl/rtc_edge_pulse.sv
module rtc_edge_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic level_q,
    output logic rise,
    output logic rise_q
);

    assign rise = level & ~level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            rise_q  <= 1'b0;
        end else begin
            level_q <= level;
            rise_q  <= rise;
        end
    end

endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen
    import rtc_periodic_pkg::*;
#(
    parameter int STAGES = DIV_STAGES,
    parameter int CW     = CTL_W,
    parameter int RW     = RATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          osc_tick,
    input  logic [CW-1:0] osc_ctl,
    input  logic [RW-1:0] rate_sel,
    input  logic          pie,
    output logic          osc_en,
    output logic          sqw,
    output logic          per_event,
    output logic          per_irq,
    output logic          upd_strobe
);

    localparam int TOP_STAGE = STAGES - 1;

    logic              div_clr;
    logic              div_adv;
    logic [STAGES-1:0] taps;
    logic              sel_tap;
    logic              per_rise;
    logic              per_irq_q;
    logic              sec_level_q;
    logic              sec_rise;

    rtc_osc_ctrl #(.CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_ctl  (osc_ctl),
        .osc_tick (osc_tick),
        .osc_en   (osc_en),
        .div_clr  (div_clr),
        .div_adv  (div_adv)
    );

    rtc_div_chain #(.STAGES(STAGES)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .adv   (div_adv),
        .taps  (taps)
    );

    rtc_rate_mux #(.STAGES(STAGES), .RW(RW)) u_mux (
        .taps     (taps),
        .rate_sel (rate_sel),
        .tap_out  (sel_tap)
    );

    // shared rate path: square wave and periodic event
    rtc_edge_pulse u_per_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (sel_tap),
        .level_q (sqw),
        .rise    (per_rise),
        .rise_q  (per_event)
    );

    // 1 Hz update strobe from the last stage
    rtc_edge_pulse u_sec_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (taps[TOP_STAGE]),
        .level_q (sec_level_q),
        .rise    (sec_rise),
        .rise_q  (upd_strobe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_irq_q <= 1'b0;
        end else begin
            per_irq_q <= per_rise & pie;
        end
    end

    assign per_irq = per_irq_q;

endmodule

module rtc_periodic_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] osc_ctl,
    input logic [3:0] rate_sel,
    input logic       pie,
    input logic       osc_en,
    input logic       sqw,
    input logic       per_event,
    input logic       per_irq,
    input logic       upd_strobe
);

    // R2
    osc_on_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(osc_ctl == 3'b010 || osc_ctl[2:1] == 2'b11) |-> osc_en);

    // R2
    osc_off_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(osc_ctl == 3'b010 || osc_ctl[2:1] == 2'b11) |-> !osc_en);

    // R8
    per_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_event |-> sqw && !$past(sqw));

    // R8
    per_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_event |=> !per_event);

    // R9
    irq_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_irq |-> per_event && $past(pie));

    // R9
    irq_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_event && $past(pie) |-> per_irq);

    // R10
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |=> !upd_strobe);

    // R6
    rate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rate_sel == 4'd0) |-> !sqw && !per_event);

    // R3
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(osc_ctl[2:1] == 2'b11, 1) && $past(osc_ctl[2:1] == 2'b11, 2)
        && $past(osc_ctl[2:1] == 2'b11, 3) |-> !sqw && !upd_strobe && !per_event);

endmodule

bind rtc_periodic_gen rtc_periodic_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_ctl    (osc_ctl),
    .rate_sel   (rate_sel),
    .pie        (pie),
    .osc_en     (osc_en),
    .sqw        (sqw),
    .per_event  (per_event),
    .per_irq    (per_irq),
    .upd_strobe (upd_strobe)
);

// File: tb/rtc_periodic_gen_bench.sv
module rtc_periodic_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b1;
    logic [2:0] osc_ctl = 3'b000;
    logic [3:0] rate_sel = 4'd0;
    logic       pie = 1'b0;
    logic       osc_en, sqw, per_event, per_irq, upd_strobe;

    int  checks = 0;
    int  errors = 0;
    bit  tick_half = 1'b0;
    bit  done = 1'b0;

    rtc_periodic_gen u_rtc_periodic_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_tick   (osc_tick),
        .osc_ctl    (osc_ctl),
        .rate_sel   (rate_sel),
        .pie        (pie),
        .osc_en     (osc_en),
        .sqw        (sqw),
        .per_event  (per_event),
        .per_irq    (per_irq),
        .upd_strobe (upd_strobe)
    );

    initial forever #4 clk = ~clk;

    // tick every cycle, or every second cycle
    initial forever begin
        @(negedge clk);
        osc_tick = tick_half ? ~osc_tick : 1'b1;
    end

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_pulse(input int limit, output bit found);
        found = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (per_event) begin
                found = 1'b1;
                break;
            end
        end
    endtask

    // skips the first pulse, then measures one full period
    task automatic measure(input int limit, output int per, output int hi);
        bit found;
        per = -1;
        hi  = 0;
        wait_pulse(limit, found);
        if (!found) return;
        wait_pulse(limit, found);
        if (!found) return;
        for (int n = 1; n <= limit; n++) begin
            @(negedge clk);
            if (sqw) hi++;
            if (per_event) begin
                per = n;
                break;
            end
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 osc_en", int'(osc_en), 0);
        check("R1 sqw", int'(sqw), 0);
        check("R1 per_event", int'(per_event), 0);
        check("R1 per_irq", int'(per_irq), 0);
        check("R1 upd_strobe", int'(upd_strobe), 0);
    endtask

    task automatic t_codes;
        for (int c = 0; c < 8; c++) begin
            osc_ctl = 3'(c);
            @(negedge clk);
            check($sformatf("R2 code %0d", c), int'(osc_en),
                  (c == 2 || c == 6 || c == 7) ? 1 : 0);
        end
    endtask

    task automatic t_hold;
        int seen = 0;
        rate_sel = 4'd3;
        osc_ctl  = 3'b111;
        idle(3);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (sqw || per_event || upd_strobe) seen++;
        end
        check("R3 hold quiet", seen, 0);
    endtask

    task automatic t_rate(input int code, input int exp_per);
        int per, hi;
        rate_sel = 4'(code);
        osc_ctl  = 3'b010;
        measure(3 * exp_per + 10, per, hi);
        check($sformatf("R5 rate %0d period", code), per, exp_per);
        check($sformatf("R7 rate %0d high", code), hi, exp_per / 2);
    endtask

    task automatic t_rate_zero;
        int seen = 0;
        osc_ctl  = 3'b010;
        rate_sel = 4'd0;
        idle(2);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (sqw || per_event) seen++;
        end
        check("R6 rate zero quiet", seen, 0);
    endtask

    task automatic t_pie;
        int ev = 0;
        int irq = 0;
        int mism = 0;
        osc_ctl  = 3'b010;
        rate_sel = 4'd4;
        pie      = 1'b0;
        idle(4);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (per_event) ev++;
            if (per_irq) irq++;
        end
        check("R8 events with pie=0", ev, 10);
        check("R9 no irq with pie=0", irq, 0);
        pie = 1'b1;
        idle(2);
        ev = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (per_event) ev++;
            if (per_event != per_irq) mism++;
        end
        check("R9 irq tracks event", mism, 0);
        check("R9 events with pie=1", ev, 10);
        pie = 1'b0;
    endtask

    task automatic t_stop;
        int ev = 0;
        int moved = 0;
        int per, hi;
        bit sq_ref;
        osc_ctl  = 3'b010;
        rate_sel = 4'd3;
        idle(10);
        osc_ctl = 3'b001;
        idle(3);
        sq_ref = sqw;
        check("R4 osc_en off", int'(osc_en), 0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (per_event) ev++;
            if (sqw != sq_ref) moved++;
        end
        check("R4 no events stopped", ev, 0);
        check("R4 sqw frozen", moved, 0);
        osc_ctl = 3'b010;
        measure(40, per, hi);
        check("R4 resumed period", per, 4);
    endtask

    task automatic t_slow_tick;
        int per, hi;
        tick_half = 1'b1;
        osc_ctl   = 3'b010;
        rate_sel  = 4'd3;
        measure(60, per, hi);
        check("R11 half tick period", per, 8);
        check("R11 half tick high", hi, 4);
        tick_half = 1'b0;
        idle(2);
    endtask

    task automatic t_update;
        int first_per = -1;
        int first_upd = -1;
        int second_upd = -1;
        int per_at_upd = -1;
        int sqw_at_upd = -1;
        rate_sel = 4'd15;
        osc_ctl  = 3'b110;
        idle(5);
        osc_ctl = 3'b010;
        for (int n = 1; n <= 49200; n++) begin
            @(negedge clk);
            if (per_event && first_per < 0) first_per = n;
            if (upd_strobe) begin
                if (first_upd < 0) begin
                    first_upd  = n;
                    per_at_upd = int'(per_event);
                    sqw_at_upd = int'(sqw);
                end else if (second_upd < 0) begin
                    second_upd = n;
                end
            end
        end
        check("R5 rate 15 first event", first_per, 8194);
        check("R10 first strobe", first_upd, 16386);
        check("R10 no event with strobe", per_at_upd, 0);
        check("R7 sqw low at strobe", sqw_at_upd, 0);
        check("R10 second strobe", second_upd, 49154);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        t_reset;
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_codes;
        t_hold;
        t_rate(3, 4);
        t_rate(4, 8);
        t_rate(1, 128);
        t_rate(2, 256);
        t_rate(9, 256);
        t_rate_zero;
        t_pie;
        t_stop;
        t_slow_tick;
        t_update;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule